// File: doc/BRIEF.md
# Two-wire serial EEPROM slave

This block is a synthesizable model of a byte-addressed serial EEPROM that sits on a two-wire bus as a slave. A fast system clock samples the serial clock and data lines. The block decodes start and stop conditions and answers the device address that matches its two strap inputs. It drives the data line only by pulling it low through an open-drain enable. Memory lives in an internal register array that clears at reset.

A master writes by sending the device address, then two word-address bytes, then one or more data bytes. The data bytes collect in a page buffer. They reach the array only when a stop condition closes the transfer. A self-timed busy window then follows, and during it the block ignores the bus completely. The master polls for the end of that window by sending start and address until it sees an acknowledge. Reads can start at the current address counter or, after a dummy write, at any address. They continue byte by byte for as long as the master acknowledges.

Top module: `ee2w_slave`

## Requirements
- R1: A falling data line while the clock is high starts a transaction, and a rising data line while the clock is high ends it at any point. The block changes its data-line drive only while the synchronized clock is low.
- R2: The device byte is sent most significant bit first and reads 1,0,1,0,0, then strap bit 1, strap bit 0, then the read/write bit (1 = read). The block acknowledges by pulling the data line low for the ninth clock. If the byte does not match, the block gives no acknowledge and stays silent until the next start.
- R3: A write sends two word-address bytes, high byte first, and every byte is acknowledged. The top bit of the 15-bit word address is ignored, and only the low log2(MEM_DEPTH) bits select a byte.
- R4: Successive data bytes in one write go to consecutive addresses. Only the low 6 address bits advance, so a byte past the end of the 64-byte page lands at the start of the same page and replaces what was buffered there. Other pages are left unchanged.
- R5: Buffered bytes reach the array only when a stop condition follows them. A repeated start discards them. A stop in the middle of a byte discards only that partial byte.
- R6: After a committed write, the block ignores the bus for BUSY_CYCLES system clocks and acknowledges no address. After that window it acknowledges again.
- R7: While the write-protect input is high, data bytes are still acknowledged, but the array is not changed and no busy window starts.
- R8: The address counter holds the last accessed address plus one. A read that sends no word address returns the byte at the counter.
- R9: In a read, each master acknowledge makes the block send the byte at the next address. The counter wraps from the last byte of the array to byte 0. A master non-acknowledge ends the read.
- R10: After reset the data line is released, the address counter is 0 and every array byte is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| strap_i | input | 2 | Device address strap bits, bit 1 sent first |
| wp_i | input | 1 | Write protect, high blocks array updates |
| sda_oe_o | output | 1 | High pulls the data line low |

## Verification
On every cycle the assertions check four things. The data-line drive moves only while the synchronized clock is low. The block never pulls the line during the busy window. A busy window opens only right after a stop. The array is written only inside that window. Only the bench scenarios can show the rest. These are the address match and mismatch, page wrap and overwrite, the discard on a repeated start or a mid-byte stop, write protect, the current-address counter and the read wrap from the last byte to byte 0. Each of these needs whole bus transactions and readback through the serial interface.

// File: rtl/ee2w_pkg.sv
package ee2w_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_DEV, ST_WAH, ST_WAL, ST_WR, ST_RD} st_e;
  localparam logic [4:0] DEV_TAG = 5'b10100;
endpackage

// File: rtl/ee2w_line_sync.sv
module ee2w_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_p, sda_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
      scl_p  <= scl_sh[SYNC_STAGES-1];
      sda_p  <= sda_sh[SYNC_STAGES-1];
    end
  end

  assign scl_o      = scl_sh[SYNC_STAGES-1];
  assign sda_o      = sda_sh[SYNC_STAGES-1];
  assign scl_rise_o = scl_o & ~scl_p;
  assign scl_fall_o = ~scl_o & scl_p;
  assign start_o    = scl_o & scl_p & sda_p & ~sda_o;
  assign stop_o     = scl_o & scl_p & ~sda_p & sda_o;
endmodule

// File: rtl/ee2w_page_buf.sv
module ee2w_page_buf #(
  parameter int AW         = 10,
  parameter int PAGE_BYTES = 64,
  localparam int PW        = $clog2(PAGE_BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          we_i,
  input  logic [PW-1:0] idx_i,
  input  logic [AW-PW-1:0] page_i,
  input  logic [7:0]    data_i,
  input  logic          commit_i,
  output logic          any_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [7:0]    mem_data_o
);
  logic [PAGE_BYTES-1:0] valid_w;
  logic [7:0]            data_w [PAGE_BYTES];
  logic [AW-PW-1:0]      page_q;
  logic [PW-1:0]         cidx_q;
  logic                  run_q;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic       v_q;
    logic [7:0] d_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q <= 1'b0;
        d_q <= '0;
      end else if (clr_i) begin
        v_q <= 1'b0;
      end else if (we_i && idx_i == PW'(g)) begin
        v_q <= 1'b1;
        d_q <= data_i;
      end else if (run_q && cidx_q == PW'(g)) begin
        v_q <= 1'b0;
      end
    end
    assign valid_w[g] = v_q;
    assign data_w[g]  = d_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= '0;
      cidx_q <= '0;
      run_q  <= 1'b0;
    end else begin
      if (we_i) page_q <= page_i;
      if (commit_i) begin
        run_q  <= 1'b1;
        cidx_q <= '0;
      end else if (run_q) begin
        cidx_q <= cidx_q + PW'(1);
        if (cidx_q == PW'(PAGE_BYTES - 1)) run_q <= 1'b0;
      end
    end
  end

  assign any_o      = |valid_w;
  assign mem_we_o   = run_q & valid_w[cidx_q];
  assign mem_addr_o = {page_q, cidx_q};
  assign mem_data_o = data_w[cidx_q];
endmodule

// File: rtl/ee2w_busy_timer.sv
module ee2w_busy_timer #(
  parameter int BUSY_CYCLES = 1000,
  parameter int MIN_CYCLES  = 64,
  localparam int LEN        = (BUSY_CYCLES > MIN_CYCLES) ? BUSY_CYCLES : MIN_CYCLES,
  localparam int CW         = $clog2(LEN + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  output logic busy_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (go_i)            cnt_q <= CW'(LEN);
    else if (cnt_q != '0)     cnt_q <= cnt_q - CW'(1);
  end

  assign busy_o = cnt_q != '0;
endmodule

// File: rtl/ee2w_array.sv
module ee2w_array #(
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/ee2w_slave.sv
module ee2w_slave
  import ee2w_pkg::*;
#(
  parameter int MEM_DEPTH   = 1024,
  parameter int PAGE_BYTES  = 64,
  parameter int BUSY_CYCLES = 1000,
  parameter int SYNC_STAGES = 2,
  localparam int AW         = $clog2(MEM_DEPTH),
  localparam int PW         = $clog2(PAGE_BYTES)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] strap_i,
  input  logic       wp_i,
  output logic       sda_oe_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic busy, buf_any, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_data, rd_data, rx_next;

  st_e         state_q;
  logic [3:0]  cnt_q;
  logic        ack_ph_q, ack_ok_q, rw_q, mack_q, sda_oe_q;
  logic [6:0]  sr_q, tx_q, wah_q;
  logic [AW-1:0] addr_q;

  logic bus_act, rx_state, byte_done, buf_we, commit_go, buf_clr;

  ee2w_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  assign bus_act   = !busy && !start_det && !stop_det;
  assign rx_state  = state_q inside {ST_DEV, ST_WAH, ST_WAL, ST_WR};
  assign rx_next   = {sr_q, sda_s};
  assign byte_done = bus_act && rx_state && !ack_ph_q && scl_rise && cnt_q == 4'd7;
  assign buf_we    = byte_done && state_q == ST_WR && !wp_i;
  assign commit_go = stop_det && !busy && buf_any;
  assign buf_clr   = start_det && !busy;

  ee2w_page_buf #(.AW(AW), .PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk_i, .rst_ni,
    .clr_i(buf_clr), .we_i(buf_we), .idx_i(addr_q[PW-1:0]), .page_i(addr_q[AW-1:PW]),
    .data_i(rx_next), .commit_i(commit_go), .any_o(buf_any),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_data_o(mem_data)
  );

  ee2w_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES), .MIN_CYCLES(PAGE_BYTES)) u_busy (
    .clk_i, .rst_ni, .go_i(commit_go), .busy_o(busy)
  );

  ee2w_array #(.DEPTH(MEM_DEPTH)) u_mem (
    .clk_i, .rst_ni, .we_i(mem_we), .waddr_i(mem_addr), .wdata_i(mem_data),
    .raddr_i(addr_q), .rdata_o(rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      ack_ph_q <= 1'b0;
      ack_ok_q <= 1'b0;
      rw_q     <= 1'b0;
      mack_q   <= 1'b0;
      sda_oe_q <= 1'b0;
      sr_q     <= '0;
      tx_q     <= '0;
      wah_q    <= '0;
      addr_q   <= '0;
    end else if (busy) begin
      state_q  <= ST_IDLE;
      ack_ph_q <= 1'b0;
      sda_oe_q <= 1'b0;
    end else if (start_det) begin
      state_q  <= ST_DEV;
      cnt_q    <= '0;
      ack_ph_q <= 1'b0;
      sda_oe_q <= 1'b0;
    end else if (stop_det) begin
      state_q  <= ST_IDLE;
      ack_ph_q <= 1'b0;
      sda_oe_q <= 1'b0;
    end else if (rx_state) begin
      if (!ack_ph_q) begin
        if (scl_rise && cnt_q < 4'd8) begin
          sr_q  <= rx_next[6:0];
          cnt_q <= cnt_q + 4'd1;
          if (cnt_q == 4'd7) begin
            ack_ok_q <= 1'b1;
            unique case (state_q)
              ST_DEV: begin
                ack_ok_q <= rx_next[7:3] == DEV_TAG && rx_next[2:1] == strap_i;
                rw_q     <= rx_next[0];
              end
              ST_WAH: wah_q  <= rx_next[6:0];
              ST_WAL: addr_q <= AW'({wah_q, rx_next});
              default: addr_q <= {addr_q[AW-1:PW], addr_q[PW-1:0] + PW'(1)};
            endcase
          end
        end
        if (scl_fall && cnt_q == 4'd8) begin
          if (ack_ok_q) begin
            sda_oe_q <= 1'b1;
            ack_ph_q <= 1'b1;
          end else begin
            state_q <= ST_IDLE;
          end
        end
      end else if (scl_fall) begin
        ack_ph_q <= 1'b0;
        cnt_q    <= '0;
        sda_oe_q <= 1'b0;
        unique case (state_q)
          ST_DEV: begin
            if (rw_q) begin
              state_q  <= ST_RD;
              tx_q     <= rd_data[6:0];
              sda_oe_q <= ~rd_data[7];
              addr_q   <= addr_q + AW'(1);
            end else begin
              state_q <= ST_WAH;
            end
          end
          ST_WAH:  state_q <= ST_WAL;
          default: state_q <= ST_WR;
        endcase
      end
    end else if (state_q == ST_RD) begin
      if (!ack_ph_q) begin
        if (scl_rise) cnt_q <= cnt_q + 4'd1;
        if (scl_fall) begin
          if (cnt_q == 4'd8) begin
            sda_oe_q <= 1'b0;
            ack_ph_q <= 1'b1;
          end else if (cnt_q != 4'd0) begin
            sda_oe_q <= ~tx_q[6];
            tx_q     <= {tx_q[5:0], 1'b0};
          end
        end
      end else begin
        if (scl_rise) mack_q <= ~sda_s;
        if (scl_fall) begin
          ack_ph_q <= 1'b0;
          cnt_q    <= '0;
          if (mack_q) begin
            tx_q     <= rd_data[6:0];
            sda_oe_q <= ~rd_data[7];
            addr_q   <= addr_q + AW'(1);
          end else begin
            state_q <= ST_IDLE;
          end
        end
      end
    end
  end

  assign sda_oe_o = sda_oe_q;
endmodule

// File: rtl/ee2w_slave_chk.sv
module ee2w_slave_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_s_i,
  input logic sda_oe_i,
  input logic busy_i,
  input logic stop_i,
  input logic mem_we_i
);
  assert_drive_scl_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_i != $past(sda_oe_i)) |-> !scl_s_i);

  assert_silent_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !sda_oe_i);

  assert_busy_after_stop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(stop_i));

  assert_commit_in_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |-> busy_i);
endmodule

bind ee2w_slave ee2w_slave_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s_i(scl_s), .sda_oe_i(sda_oe_o),
  .busy_i(busy), .stop_i(stop_det), .mem_we_i(mem_we)
);

// File: tb/ee2w_slave_test.sv
module ee2w_slave_test;
  localparam int Q = 8;
  localparam logic [1:0] STRAP = 2'b10;
  localparam logic [7:0] DEV_W = {5'b10100, STRAP, 1'b0};
  localparam logic [7:0] DEV_R = {5'b10100, STRAP, 1'b1};
  // {word address, data}
  localparam logic [23:0] VEC [4] = '{24'h0000A5, 24'h01233C, 24'h83FF77, 24'h044001};

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic sda_oe, sda_line;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;
  logic [7:0] wbuf [70];
  logic [7:0] rbuf [4];

  always #2 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  ee2w_slave #(.BUSY_CYCLES(600)) uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .strap_i(STRAP), .wp_i(wp), .sda_oe_o(sda_oe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bit_x(input logic b, output logic s);
    sda_m = b; tick(Q);
    scl = 1'b1; tick(Q);
    s = sda_line; tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_x(b[i], s);
    bit_x(1'b1, s);
    ack = !s;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_x(1'b1, s);
      b[i] = s;
    end
    bit_x(!mack, s);
  endtask

  task automatic write_seq(input logic [15:0] a, input int n, input bit do_stop, output logic ok);
    logic k;
    bus_start();
    send_byte(DEV_W, k); ok = k;
    send_byte(a[15:8], k); ok &= k;
    send_byte(a[7:0], k); ok &= k;
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], k); ok &= k;
    end
    if (do_stop) bus_stop();
  endtask

  task automatic cur_read(input int n);
    logic k;
    send_byte(DEV_R, k);
    for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
    bus_stop();
  endtask

  task automatic read_seq(input logic [15:0] a, input int n);
    logic ok;
    write_seq(a, 0, 1'b0, ok);
    bus_start();
    cur_read(n);
  endtask

  task automatic poll(output int tries);
    logic k;
    tries = 0;
    for (int i = 0; i < 20; i++) begin
      tries++;
      bus_start();
      send_byte(DEV_W, k);
      bus_stop();
      if (k) break;
    end
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic ok, k, s;
    int t;
    tick(5);
    rst_n = 1'b1;
    tick(5);

    // R10: reset state
    chk("R10 sda released", sda_oe, 0);
    bus_start();
    cur_read(1);
    chk("R10 mem/counter zero", rbuf[0], 8'h00);

    // R1: stop mid device byte aborts, next start works
    bus_start();
    bit_x(1'b1, s); bit_x(1'b0, s); bit_x(1'b1, s);
    bus_stop();
    bus_start();
    send_byte(DEV_W, k);
    bus_stop();
    chk("R1 restart ack", k, 1);

    // R2: address matching
    bus_start(); send_byte(8'hA0, k); bus_stop();
    chk("R2 strap mismatch nack", k, 0);
    bus_start(); send_byte(8'hB4, k); bus_stop();
    chk("R2 tag mismatch nack", k, 0);
    bus_start(); send_byte(DEV_R, k); recv_byte(1'b0, rbuf[0]); bus_stop();
    chk("R2 read match ack", k, 1);

    // R3/R6: vector table of byte writes with readback
    for (int i = 0; i < 4; i++) begin
      wbuf[0] = VEC[i][7:0];
      write_seq(VEC[i][23:8], 1, 1'b1, ok);
      chk("R3 write acks", ok, 1);
      poll(t);
      if (i == 0) begin
        chk("R6 busy nacks first poll", int'(t > 1), 1);
        chk("R6 ready after window", int'(t <= 5), 1);
      end
      read_seq(VEC[i][23:8] & 16'h03FF, 1);
      chk("R3 readback", rbuf[0], VEC[i][7:0]);
    end

    // R4: page wrap from index 60 of page at 0x080
    for (int i = 0; i < 6; i++) wbuf[i] = 8'hD0 + 8'(i);
    write_seq(16'h00BC, 6, 1'b1, ok);
    chk("R4 page acks", ok, 1);
    poll(t);
    read_seq(16'h0080, 3);
    chk("R4 wrap byte0", rbuf[0], 8'hD4);
    chk("R4 wrap byte1", rbuf[1], 8'hD5);
    chk("R4 untouched in page", rbuf[2], 8'h00);
    read_seq(16'h00BF, 2);
    chk("R4 page end", rbuf[0], 8'hD3);
    chk("R4 next page untouched", rbuf[1], 8'h00);

    // R4: 65 bytes overwrite the first slot
    for (int i = 0; i < 65; i++) wbuf[i] = 8'(i + 1);
    write_seq(16'h00C0, 65, 1'b1, ok);
    chk("R4 long page acks", ok, 1);
    poll(t);
    read_seq(16'h00C0, 1);
    chk("R4 overwrite", rbuf[0], 8'h41);
    // R8: current address continues after last read
    bus_start();
    cur_read(1);
    chk("R8 current address", rbuf[0], 8'h02);

    // R5: repeated start discards buffered data
    wbuf[0] = 8'h55;
    write_seq(16'h0010, 1, 1'b0, ok);
    bus_start();
    bus_stop();
    poll(t);
    chk("R5 no busy after discard", t, 1);
    // R5: stop mid-byte keeps whole bytes only
    wbuf[0] = 8'h66;
    write_seq(16'h0011, 1, 1'b0, ok);
    bit_x(1'b1, s); bit_x(1'b0, s); bit_x(1'b1, s); bit_x(1'b0, s);
    bus_stop();
    poll(t);
    read_seq(16'h0010, 3);
    chk("R5 discarded write", rbuf[0], 8'h00);
    chk("R5 committed byte", rbuf[1], 8'h66);
    chk("R5 partial byte dropped", rbuf[2], 8'h00);

    // R7: write protect
    wp = 1'b1;
    wbuf[0] = 8'h99;
    write_seq(16'h0011, 1, 1'b1, ok);
    chk("R7 acks under protect", ok, 1);
    poll(t);
    chk("R7 no busy window", t, 1);
    wp = 1'b0;
    read_seq(16'h0011, 1);
    chk("R7 array unchanged", rbuf[0], 8'h66);

    // R9: sequential read wraps from last byte to 0
    read_seq(16'h03FE, 3);
    chk("R9 before wrap", rbuf[0], 8'h00);
    chk("R9 last byte", rbuf[1], 8'h77);
    chk("R9 wrapped to 0", rbuf[2], 8'hA5);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule